// File: doc/BRIEF.md
# Operand Addressing Mode Unit

This unit resolves where the two operands of a 16-bit register-oriented instruction live. For each operand it takes a mode code, a register index and an extension word. It also takes the whole register file, including the program counter in slot 0, and a byte/word flag shared by both operands. From these it reports whether the operand is a register, a memory location or an immediate value. It also gives the effective memory address, how many extension words the instruction uses, and whether a pointer register has to be bumped after an autoincrement access. The source side understands seven modes. The destination side understands only the register, indexed, PC-relative and absolute forms. Any other destination code, and the unused source code, are reported as illegal.

The address arithmetic is combinational and wraps modulo 2^16. Requests enter through a valid/ready port and leave through a single output register with its own valid/ready pair. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is valid but not yet taken holds every output field unchanged until `out_ready` rises. The autoincrement write-back is a one-cycle strobe at the output handshake. It fires once per instruction however long the stall lasts, and the register file applies it on the following clock edge.

Top module: `opnd_addr_unit`

## Requirements
- R1: A request accepted on a clock edge where `in_valid` and `in_ready` are both high appears with `out_valid` high after that edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs stay constant.
- R2: Source or destination mode 0 (register) gives kind 0 (register), address 0 and uses no extension word.
- R3: Mode 1 (indexed) gives kind 1 (memory) with address = extension word + R[n], wrapping at 2^16, and uses one extension word.
- R4: Mode 2 (symbolic) gives kind 1 with address = R[0] + extension word, wrapping at 2^16, whatever the register index is, and uses one extension word.
- R5: Mode 3 (absolute) gives kind 1 with address = extension word and uses one extension word.
- R6: Source mode 4 (indirect) gives kind 1 with address = R[n] and uses no extension word.
- R7: Source mode 5 (indirect autoincrement) gives kind 1 with address = R[n] and uses no extension word. At the output handshake `wb_en` is high for that one cycle, with `wb_idx` = n and `wb_data` = R[n] + 2 for a word access or R[n] + 1 when `byte_op` is 1, wrapping at 2^16. In every other case `wb_en` stays low.
- R8: Source mode 6 (immediate) gives kind 2 (immediate), `src_imm` = extension word and address 0, and uses one extension word. `src_imm` is 0 in every other mode. The destination kind is never 2.
- R9: Destination modes 4 to 7 and source mode 7 set `illegal`. In that case both kinds, both addresses, `src_imm` and `ext_count` are 0 and no write-back occurs.
- R10: `ext_count` is the number of extension words used by the source (modes 1, 2, 3, 6) plus those used by the destination (modes 1, 2, 3), giving a value from 0 to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| src_mode | input | 3 | Source mode code |
| src_reg | input | 4 | Source register index |
| src_ext | input | 16 | Source extension word |
| dst_mode | input | 3 | Destination mode code |
| dst_reg | input | 4 | Destination register index |
| dst_ext | input | 16 | Destination extension word |
| byte_op | input | 1 | 1 = byte access, 0 = word access |
| regs | input | 256 | Register file, R[i] at bits 16*i+15 down to 16*i |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| src_kind | output | 2 | Source kind: 0 register, 1 memory, 2 immediate |
| src_addr | output | 16 | Source effective address |
| src_imm | output | 16 | Source immediate value |
| dst_kind | output | 2 | Destination kind: 0 register, 1 memory |
| dst_addr | output | 16 | Destination effective address |
| ext_count | output | 2 | Extension words used by the instruction |
| illegal | output | 1 | Mode combination not supported |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_idx | output | 4 | Register to write back |
| wb_data | output | 16 | Incremented pointer value |

## Verification
The directed cases cover carry-out wrap in indexed and PC-relative sums, and autoincrement of 0xFFFF and 0xFFFE in byte and word sizes. A unit that drops the carry incorrectly or uses the wrong step gives a wrong address or `wb_data`. Symbolic mode is driven with a register index that points to a register other than R0. A design that adds the named register instead of the program counter gives an address that does not match. Stalls of several cycles on the output check that the result holds steady and that the write-back strobe fires only once, in the handshake cycle; a design that strobes while stalled would bump the pointer more than once. Illegal destination codes are paired with source modes that would otherwise use an extension word or write back. This catches a design that lets those side effects through.

// File: rtl/opau_pkg.sv
package opau_pkg;

  typedef enum logic [2:0] {
    AM_REG    = 3'd0,
    AM_INDEX  = 3'd1,
    AM_SYMB   = 3'd2,
    AM_ABS    = 3'd3,
    AM_IND    = 3'd4,
    AM_INDINC = 3'd5,
    AM_IMM    = 3'd6,
    AM_RSVD   = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    OK_REG = 2'd0,
    OK_MEM = 2'd1,
    OK_IMM = 2'd2
  } okind_e;

endpackage

// File: rtl/opau_reg_pick.sv
module opau_reg_pick #(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic [NREG*DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]       idx,
  output logic [DATA_W-1:0]      value
);

  logic [DATA_W-1:0] slot [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign slot[g] = regs[g*DATA_W +: DATA_W];
  end

  assign value = slot[idx];

endmodule

// File: rtl/opau_src_calc.sv
module opau_src_calc
  import opau_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  amode_e            mode,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] ext,
  input  logic              byte_op,
  output okind_e            kind,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] imm,
  output logic              uses_ext,
  output logic              legal,
  output logic              inc_en,
  output logic [DATA_W-1:0] inc_val
);

  localparam logic [DATA_W-1:0] STEP_BYTE = DATA_W'(1);
  localparam logic [DATA_W-1:0] STEP_WORD = DATA_W'(2);

  always_comb begin
    kind     = OK_REG;
    addr     = '0;
    imm      = '0;
    uses_ext = 1'b0;
    legal    = 1'b1;
    inc_en   = 1'b0;
    inc_val  = rn_val + (byte_op ? STEP_BYTE : STEP_WORD);
    unique case (mode)
      AM_REG: ;
      AM_INDEX: begin
        kind = OK_MEM; addr = ext + rn_val; uses_ext = 1'b1;
      end
      AM_SYMB: begin
        kind = OK_MEM; addr = pc_val + ext; uses_ext = 1'b1;
      end
      AM_ABS: begin
        kind = OK_MEM; addr = ext; uses_ext = 1'b1;
      end
      AM_IND: begin
        kind = OK_MEM; addr = rn_val;
      end
      AM_INDINC: begin
        kind = OK_MEM; addr = rn_val; inc_en = 1'b1;
      end
      AM_IMM: begin
        kind = OK_IMM; imm = ext; uses_ext = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/opau_dst_calc.sv
module opau_dst_calc
  import opau_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  amode_e            mode,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] pc_val,
  input  logic [DATA_W-1:0] ext,
  output okind_e            kind,
  output logic [DATA_W-1:0] addr,
  output logic              uses_ext,
  output logic              legal
);

  always_comb begin
    kind     = OK_REG;
    addr     = '0;
    uses_ext = 1'b0;
    legal    = 1'b1;
    unique case (mode)
      AM_REG: ;
      AM_INDEX: begin
        kind = OK_MEM; addr = ext + rn_val; uses_ext = 1'b1;
      end
      AM_SYMB: begin
        kind = OK_MEM; addr = pc_val + ext; uses_ext = 1'b1;
      end
      AM_ABS: begin
        kind = OK_MEM; addr = ext; uses_ext = 1'b1;
      end
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opau_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 16,
  parameter int PC_IDX = 0,
  localparam int IDX_W = $clog2(NREG),
  localparam int RF_W  = NREG * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        src_mode,
  input  logic [IDX_W-1:0]  src_reg,
  input  logic [DATA_W-1:0] src_ext,
  input  logic [2:0]        dst_mode,
  input  logic [IDX_W-1:0]  dst_reg,
  input  logic [DATA_W-1:0] dst_ext,
  input  logic              byte_op,
  input  logic [RF_W-1:0]   regs,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        src_kind,
  output logic [DATA_W-1:0] src_addr,
  output logic [DATA_W-1:0] src_imm,
  output logic [1:0]        dst_kind,
  output logic [DATA_W-1:0] dst_addr,
  output logic [1:0]        ext_count,
  output logic              illegal,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);

  logic [DATA_W-1:0] s_rn, d_rn, pc_val;
  okind_e            s_kind, d_kind;
  logic [DATA_W-1:0] s_addr, s_imm, d_addr, s_inc_val;
  logic              s_uses, d_uses, s_legal, d_legal, s_inc;

  opau_reg_pick #(.DATA_W(DATA_W), .NREG(NREG)) u_pick_src (
    .regs(regs), .idx(src_reg), .value(s_rn));
  opau_reg_pick #(.DATA_W(DATA_W), .NREG(NREG)) u_pick_dst (
    .regs(regs), .idx(dst_reg), .value(d_rn));
  opau_reg_pick #(.DATA_W(DATA_W), .NREG(NREG)) u_pick_pc (
    .regs(regs), .idx(IDX_W'(PC_IDX)), .value(pc_val));

  opau_src_calc #(.DATA_W(DATA_W)) u_src (
    .mode(amode_e'(src_mode)), .rn_val(s_rn), .pc_val(pc_val),
    .ext(src_ext), .byte_op(byte_op), .kind(s_kind), .addr(s_addr),
    .imm(s_imm), .uses_ext(s_uses), .legal(s_legal), .inc_en(s_inc),
    .inc_val(s_inc_val));

  opau_dst_calc #(.DATA_W(DATA_W)) u_dst (
    .mode(amode_e'(dst_mode)), .rn_val(d_rn), .pc_val(pc_val),
    .ext(dst_ext), .kind(d_kind), .addr(d_addr), .uses_ext(d_uses),
    .legal(d_legal));

  // Combine the two sides; an illegal pair suppresses every side effect.
  logic              ok;
  logic [1:0]        n_src_kind, n_dst_kind, n_ext;
  logic [DATA_W-1:0] n_src_addr, n_src_imm, n_dst_addr;
  logic              n_inc;

  always_comb begin
    ok         = s_legal & d_legal;
    n_src_kind = ok ? 2'(s_kind) : 2'(OK_REG);
    n_dst_kind = ok ? 2'(d_kind) : 2'(OK_REG);
    n_src_addr = ok ? s_addr : '0;
    n_src_imm  = ok ? s_imm  : '0;
    n_dst_addr = ok ? d_addr : '0;
    n_ext      = ok ? (2'(s_uses) + 2'(d_uses)) : 2'd0;
    n_inc      = ok & s_inc;
  end

  // Output register stage
  logic take;
  logic inc_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      src_kind  <= '0;
      src_addr  <= '0;
      src_imm   <= '0;
      dst_kind  <= '0;
      dst_addr  <= '0;
      ext_count <= '0;
      illegal   <= 1'b0;
      inc_q     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        src_kind  <= n_src_kind;
        src_addr  <= n_src_addr;
        src_imm   <= n_src_imm;
        dst_kind  <= n_dst_kind;
        dst_addr  <= n_dst_addr;
        ext_count <= n_ext;
        illegal   <= !ok;
        inc_q     <= n_inc;
        wb_idx    <= src_reg;
        wb_data   <= s_inc_val;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign wb_en = out_valid && out_ready && inc_q;

  // R1
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(src_addr) &&
      $stable(dst_addr) && $stable(src_kind) && $stable(dst_kind) &&
      $stable(ext_count) && $stable(wb_data) && $stable(illegal));

  // R7
  wb_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> src_kind == 2'(OK_MEM) && !illegal && ext_count <= 2'd1);

  // R8
  dst_not_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> dst_kind != 2'(OK_IMM));

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && illegal |-> ext_count == 2'd0 && src_kind == 2'(OK_REG) &&
      dst_kind == 2'(OK_REG) && !wb_en);

  // R10
  ext_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && src_kind == 2'(OK_REG) && dst_kind == 2'(OK_REG) |->
      ext_count == 2'd0);

endmodule

// File: tb/sim_opnd_addr_unit.sv
module sim_opnd_addr_unit;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid = 1'b0, out_ready = 1'b0, byte_op = 1'b0;
  logic [2:0]  src_mode = '0, dst_mode = '0;
  logic [3:0]  src_reg = '0, dst_reg = '0;
  logic [15:0] src_ext = '0, dst_ext = '0;
  logic [15:0] rf [16];
  logic [255:0] regs;
  logic        in_ready, out_valid, illegal, wb_en;
  logic [1:0]  src_kind, dst_kind, ext_count;
  logic [15:0] src_addr, src_imm, dst_addr, wb_data;
  logic [3:0]  wb_idx;

  always_comb
    for (int i = 0; i < 16; i++) regs[i*16 +: 16] = rf[i];

  opnd_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_mode(src_mode), .src_reg(src_reg), .src_ext(src_ext),
    .dst_mode(dst_mode), .dst_reg(dst_reg), .dst_ext(dst_ext),
    .byte_op(byte_op), .regs(regs), .out_valid(out_valid),
    .out_ready(out_ready), .src_kind(src_kind), .src_addr(src_addr),
    .src_imm(src_imm), .dst_kind(dst_kind), .dst_addr(dst_addr),
    .ext_count(ext_count), .illegal(illegal), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_data(wb_data));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Expected result, from the requirements
  logic [1:0]  e_sk, e_dk, e_ext;
  logic [15:0] e_sa, e_si, e_da, e_wd;
  logic        e_ill, e_wb;

  task automatic model(input logic [2:0] sm, input logic [3:0] sr,
                       input logic [15:0] se, input logic [2:0] dm,
                       input logic [3:0] dr, input logic [15:0] de,
                       input logic bo);
    e_sk = 0; e_dk = 0; e_sa = 0; e_si = 0; e_da = 0; e_ext = 0;
    e_wb = 0; e_wd = rf[sr] + (bo ? 16'd1 : 16'd2);
    e_ill = (sm == 3'd7) || (dm > 3'd3);
    if (!e_ill) begin
      case (sm)
        3'd1: begin e_sk = 1; e_sa = se + rf[sr]; e_ext++; end
        3'd2: begin e_sk = 1; e_sa = rf[0] + se; e_ext++; end
        3'd3: begin e_sk = 1; e_sa = se; e_ext++; end
        3'd4: begin e_sk = 1; e_sa = rf[sr]; end
        3'd5: begin e_sk = 1; e_sa = rf[sr]; e_wb = 1; end
        3'd6: begin e_sk = 2; e_si = se; e_ext++; end
        default: ;
      endcase
      case (dm)
        3'd1: begin e_dk = 1; e_da = de + rf[dr]; e_ext++; end
        3'd2: begin e_dk = 1; e_da = rf[0] + de; e_ext++; end
        3'd3: begin e_dk = 1; e_da = de; e_ext++; end
        default: ;
      endcase
    end
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2"; 3'd1: return "R3"; 3'd2: return "R4";
      3'd3: return "R5"; 3'd4: return "R6"; 3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input logic [2:0] sm, input logic [3:0] sr,
                     input logic [15:0] se, input logic [2:0] dm,
                     input logic [3:0] dr, input logic [15:0] de,
                     input logic bo, input int stall);
    string rs, rd;
    @(negedge clk);
    src_mode = sm; src_reg = sr; src_ext = se;
    dst_mode = dm; dst_reg = dr; dst_ext = de; byte_op = bo;
    in_valid = 1'b1; out_ready = 1'b0;
    model(sm, sr, se, dm, dr, de, bo);
    rs = e_ill ? "R9" : req_of(sm);
    rd = e_ill ? "R9" : (dm == 0 ? "R2" : req_of(dm));
    chk(in_ready === 1'b1, "R1", "in_ready idle", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    src_ext = ~se; dst_ext = ~de; src_mode = 3'd0; dst_mode = 3'd0;
    chk(out_valid === 1'b1, "R1", "out_valid", out_valid, 1);
    chk(src_kind === e_sk, rs, "src_kind", src_kind, e_sk);
    chk(src_addr === e_sa, rs, "src_addr", src_addr, e_sa);
    chk(src_imm === e_si, rs, "src_imm", src_imm, e_si);
    chk(dst_kind === e_dk, rd, "dst_kind", dst_kind, e_dk);
    chk(dst_addr === e_da, rd, "dst_addr", dst_addr, e_da);
    chk(ext_count === e_ext, "R10", "ext_count", ext_count, e_ext);
    chk(illegal === e_ill, "R9", "illegal", illegal, e_ill);
    chk(wb_en === 1'b0, "R7", "wb_en stalled", wb_en, 0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R1", "in_ready stalled", in_ready, 0);
      chk(src_addr === e_sa && dst_addr === e_da, "R1", "held addr",
          src_addr, e_sa);
      chk(wb_en === 1'b0, "R7", "wb_en stalled", wb_en, 0);
    end
    out_ready = 1'b1;
    #1;
    chk(in_ready === 1'b1, "R1", "in_ready drain", in_ready, 1);
    chk(wb_en === e_wb, "R7", "wb_en handshake", wb_en, e_wb);
    if (e_wb) begin
      chk(wb_idx === sr, "R7", "wb_idx", wb_idx, sr);
      chk(wb_data === e_wd, "R7", "wb_data", wb_data, e_wd);
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid === 1'b0, "R1", "out_valid drained", out_valid, 0);
    chk(wb_en === 1'b0, "R7", "wb_en after", wb_en, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    for (int i = 0; i < 16; i++) rf[i] = 16'(i * 16'h1111);
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(wb_en === 1'b0, "R7", "reset wb_en", wb_en, 0);
    rst_n = 1'b1;

    // Directed corner cases
    rf[0] = 16'hFFF0; rf[5] = 16'h0004; rf[6] = 16'hFFFF; rf[7] = 16'hFFFE;
    run(3'd1, 4'd5, 16'hFFFE, 3'd0, 4'd3, 16'h0, 1'b0, 0);  // R3 wrap
    run(3'd2, 4'd5, 16'h0020, 3'd2, 4'd7, 16'h0011, 1'b0, 1); // R4 uses R0
    run(3'd3, 4'd9, 16'hABCD, 3'd3, 4'd1, 16'h1234, 1'b0, 0); // R5
    run(3'd4, 4'd6, 16'h5555, 3'd1, 4'd7, 16'h0003, 1'b0, 0); // R6
    run(3'd5, 4'd6, 16'h0, 3'd0, 4'd1, 16'h0, 1'b1, 3);      // R7 byte wrap
    run(3'd5, 4'd6, 16'h0, 3'd0, 4'd1, 16'h0, 1'b0, 2);      // R7 word
    run(3'd5, 4'd7, 16'h0, 3'd3, 4'd1, 16'h0100, 1'b0, 0);   // R7 +2 wrap
    run(3'd6, 4'd2, 16'h002D, 3'd1, 4'd5, 16'h0010, 1'b0, 0); // R8, R10 = 2
    run(3'd0, 4'd4, 16'h0, 3'd0, 4'd4, 16'h0, 1'b0, 0);      // R2
    run(3'd5, 4'd6, 16'h1, 3'd4, 4'd1, 16'h1, 1'b0, 1);      // R9 dst ind
    run(3'd6, 4'd6, 16'h1, 3'd6, 4'd1, 16'h1, 1'b0, 0);      // R9 dst imm
    run(3'd7, 4'd6, 16'h1, 3'd1, 4'd1, 16'h1, 1'b0, 0);      // R9 src rsvd

    // Constrained random
    for (int t = 0; t < 400; t++) begin
      for (int i = 0; i < 16; i++) rf[i] = 16'($urandom);
      run(3'($urandom_range(0, 6)), 4'($urandom), 16'($urandom),
          ($urandom_range(0, 9) == 0) ? 3'($urandom_range(4, 7))
                                      : 3'($urandom_range(0, 3)),
          4'($urandom), 16'($urandom), 1'($urandom),
          int'($urandom_range(0, 2)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_chk, n_fail);
    $finish;
  end

endmodule